// File: doc/BRIEF.md
# REST Request Command Decoder

This block turns the first line of an HTTP/1.1 request into a single command for a tensor accelerator. The request comes in one byte per beat from a TCP offload engine on a stream interface with valid, ready and last. The decoder reads the method, the resource path and the query string. It converts the decimal numbers it finds there and matches the route against a fixed table. When the packet ends, it presents one record on a valid/ready command port. The record selects one of four actions: a memory download, a memory upload, a tensor-core launch, or a launch of the auxiliary processing logic. Anything it cannot decode becomes an error record. No processor is involved at any step.

The method, target and version are split on single spaces. Parsing ends at the first CR LF, and every byte after that, up to the end of the packet, is consumed and ignored. The command appears one cycle after the last byte is accepted, so the decoder adds very little to the network-to-core latency budget of about one hundred cycles.

Top module: `rest_cmd_decoder`

## Requirements
- R1: `GET /memory/<a>?size=<n>` yields opcode 0 (memory read), with cmdAddr = a and cmdSize = n.
- R2: `PUT /memory/<a>` yields opcode 1 (memory write) with cmdAddr = a. cmdSize comes from an optional `size=<n>` query and is 0 when the query is absent.
- R3: `POST /device?insn_addr=<a>&insn_count=<c>` yields opcode 2 (core launch) with cmdAddr = a and cmdSize = c. The two keys are accepted in either order.
- R4: `POST /processing_logic` yields opcode 3 (auxiliary launch) with cmdAddr = 0 and cmdSize = 0.
- R5: Each of the following yields opcode 7 with cmdErr = 1 and both numeric fields 0:
  - an unknown method, path or query key;
  - a missing, empty or repeated parameter;
  - a non-digit inside a number.
- R6: A number is unsigned decimal of up to 64 bits. The value 18446744073709551615 is accepted, and any larger value yields opcode 7.
- R7: Bytes after the first CR LF, up to last, have no effect on the command. A packet that ends before CR LF yields opcode 7.
- R8: Exactly one command is produced per packet. cmdValid rises in the cycle after the beat carrying last is accepted.
- R9: While cmdValid is high and cmdReady is low:
  - the command fields stay stable;
  - inReady is low;
  - cmdValid remains high until a cycle in which cmdReady is high.
- R10: A synchronous active-high reset clears cmdValid, raises inReady and discards any partly parsed request, so the next packet decodes from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inData | input | 8 | Request byte |
| inValid | input | 1 | Byte valid |
| inLast | input | 1 | Final byte of the request packet |
| inReady | output | 1 | Byte accepted when high together with inValid |
| cmdValid | output | 1 | Command record valid |
| cmdReady | input | 1 | Command consumer ready |
| cmdOp | output | 3 | 0 read, 1 write, 2 core launch, 3 auxiliary launch, 7 error |
| cmdAddr | output | 64 | Memory or instruction start address |
| cmdSize | output | 64 | Transfer size or instruction count |
| cmdErr | output | 1 | Set with opcode 7 |

## Verification
The bench targets the following corner cases:
- The largest 64-bit value and that value plus one. A wrong carry check would let the second wrap around to a small address.
- The device parameters in swapped order, and a repeated key. A decoder that assumed a fixed order would swap address and count, and one without the repeat check would silently concatenate digits.
- Trailing header lines that contain route-like text, and a packet cut off before CR LF. A parser that did not stop at the first line end would mis-route the first case or launch on the second.
- A stalled command port. An output that moved or accepted bytes during the stall would drop or corrupt a command.

// File: rtl/rest_cmd_pkg.sv
`timescale 1ns/1ps
package rest_cmd_pkg;
  localparam int SEG_CHARS = 16;
  localparam int SEG_W = SEG_CHARS * 8;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_LAUNCH = 3'd2,
    OP_AUX    = 3'd3,
    OP_ERR    = 3'd7
  } cmd_op_e;

  // Strobes from the parse controller to the field datapath
  typedef struct packed {
    logic    clrAll;
    logic    segPush;
    logic    segClr;
    logic    digitAddr;
    logic    digitSize;
    logic    emit;
    cmd_op_e op;
  } dp_strobe_t;

  localparam logic [SEG_W-1:0] K_GET    = {104'd0, "GET"};
  localparam logic [SEG_W-1:0] K_PUT    = {104'd0, "PUT"};
  localparam logic [SEG_W-1:0] K_POST   = {96'd0, "POST"};
  localparam logic [SEG_W-1:0] K_MEMORY = {80'd0, "memory"};
  localparam logic [SEG_W-1:0] K_DEVICE = {80'd0, "device"};
  localparam logic [SEG_W-1:0] K_AUX    = "processing_logic";
  localparam logic [SEG_W-1:0] K_SIZE   = {96'd0, "size"};
  localparam logic [SEG_W-1:0] K_IADDR  = {56'd0, "insn_addr"};
  localparam logic [SEG_W-1:0] K_ICOUNT = {48'd0, "insn_count"};
endpackage

// File: rtl/rest_field_dp.sv
`timescale 1ns/1ps
module rest_field_dp
  import rest_cmd_pkg::*;
#(
  parameter int FIELD_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         inByte,
  input  dp_strobe_t         stb,
  input  logic               cmdReady,
  output logic               cmdValid,
  output logic [2:0]         cmdOp,
  output logic [FIELD_W-1:0] cmdAddr,
  output logic [FIELD_W-1:0] cmdSize,
  output logic               cmdErr,
  output logic [SEG_W-1:0]   segWord,
  output logic               segOver,
  output logic               haveAddr,
  output logic               haveSize,
  output logic               ovf
);
  localparam int PROD_W = FIELD_W + 4;
  localparam int NUM_FIELDS = 2;  // index 0 address, 1 size/count

  logic [FIELD_W-1:0]    acc      [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] have;
  logic [NUM_FIELDS-1:0] ovfBit;
  logic [NUM_FIELDS-1:0] digitEn;
  logic [3:0]            digit;

  assign digit   = inByte[3:0];
  assign digitEn = {stb.digitSize, stb.digitAddr};

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [PROD_W-1:0] prod;
    assign prod = {4'b0, acc[g]} * PROD_W'(10) + PROD_W'(digit);
    always_ff @(posedge clk) begin
      if (rst || stb.clrAll) begin
        acc[g]    <= '0;
        have[g]   <= 1'b0;
        ovfBit[g] <= 1'b0;
      end else if (digitEn[g]) begin
        acc[g]  <= prod[FIELD_W-1:0];
        have[g] <= 1'b1;
        if (prod[PROD_W-1:FIELD_W] != '0) ovfBit[g] <= 1'b1;
      end
    end
  end

  assign haveAddr = have[0];
  assign haveSize = have[1];
  assign ovf      = |ovfBit;

  always_ff @(posedge clk) begin
    if (rst || stb.clrAll || stb.segClr) begin
      segWord <= '0;
      segOver <= 1'b0;
    end else if (stb.segPush) begin
      segWord <= {segWord[SEG_W-9:0], inByte};
      if (segWord[SEG_W-1 -: 8] != 8'd0) segOver <= 1'b1;
    end
  end

  logic carries;
  assign carries = (stb.op == OP_READ) || (stb.op == OP_WRITE) || (stb.op == OP_LAUNCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdValid <= 1'b0;
      cmdOp    <= 3'd0;
      cmdAddr  <= '0;
      cmdSize  <= '0;
      cmdErr   <= 1'b0;
    end else if (stb.emit) begin
      cmdValid <= 1'b1;
      cmdOp    <= stb.op;
      cmdErr   <= (stb.op == OP_ERR);
      cmdAddr  <= carries ? acc[0] : '0;
      cmdSize  <= carries ? acc[1] : '0;
    end else if (cmdReady) begin
      cmdValid <= 1'b0;
    end
  end
endmodule

// File: rtl/rest_parse_ctrl.sv
`timescale 1ns/1ps
module rest_parse_ctrl
  import rest_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       inByte,
  input  logic             accept,
  input  logic             inLast,
  input  logic [SEG_W-1:0] segWord,
  input  logic             segOver,
  input  logic             haveAddr,
  input  logic             haveSize,
  input  logic             ovf,
  output dp_strobe_t       stb
);
  localparam logic [7:0] CH_SP = 8'h20, CH_CR = 8'h0D, CH_LF = 8'h0A;
  localparam logic [7:0] CH_SL = 8'h2F, CH_QM = 8'h3F, CH_EQ = 8'h3D, CH_AMP = 8'h26;

  typedef enum logic [3:0] {
    S_METH, S_SLASH, S_SEG, S_ADDR, S_QKEY, S_QVAL, S_VER, S_LF, S_DRAIN
  } state_e;
  typedef enum logic [1:0] {M_NONE, M_GET, M_PUT, M_POST} meth_e;
  typedef enum logic [1:0] {RT_NONE, RT_MEM, RT_DEV, RT_AUX} route_e;
  typedef enum logic {F_ADDR, F_SIZE} field_e;

  state_e state, nState;
  meth_e  method, nMethod;
  route_e route, nRoute;
  field_e fieldSel, nField;
  logic   parseErr, setErr;

  logic isDigit, lineDone, fieldEmpty;
  assign isDigit    = (inByte >= 8'h30) && (inByte <= 8'h39);
  assign lineDone   = (state == S_DRAIN && !parseErr) || (state == S_LF && inByte == CH_LF);
  assign fieldEmpty = (fieldSel == F_ADDR) ? !haveAddr : !haveSize;

  function automatic logic hit(input logic [SEG_W-1:0] k);
    return !segOver && (segWord == k);
  endfunction

  cmd_op_e finalOp;
  always_comb begin
    if (!lineDone || ovf)                                             finalOp = OP_ERR;
    else if (method == M_GET  && route == RT_MEM && haveAddr && haveSize) finalOp = OP_READ;
    else if (method == M_PUT  && route == RT_MEM && haveAddr)             finalOp = OP_WRITE;
    else if (method == M_POST && route == RT_DEV && haveAddr && haveSize) finalOp = OP_LAUNCH;
    else if (method == M_POST && route == RT_AUX)                         finalOp = OP_AUX;
    else                                                                  finalOp = OP_ERR;
  end

  always_comb begin
    stb     = '0;
    stb.op  = OP_ERR;
    nState  = state;
    nMethod = method;
    nRoute  = route;
    nField  = fieldSel;
    setErr  = 1'b0;
    if (accept) begin
      if (inLast) begin
        stb.emit   = 1'b1;
        stb.clrAll = 1'b1;
        stb.op     = finalOp;
      end else begin
        unique case (state)
          S_METH: begin
            if (inByte == CH_SP) begin
              stb.segClr = 1'b1;
              nState     = S_SLASH;
              if (hit(K_GET))       nMethod = M_GET;
              else if (hit(K_PUT))  nMethod = M_PUT;
              else if (hit(K_POST)) nMethod = M_POST;
              else                  setErr  = 1'b1;
            end else stb.segPush = 1'b1;
          end
          S_SLASH: begin
            if (inByte == CH_SL) nState = S_SEG;
            else                 setErr = 1'b1;
          end
          S_SEG: begin
            if (inByte == CH_SL || inByte == CH_QM || inByte == CH_SP) begin
              stb.segClr = 1'b1;
              if (inByte == CH_SL && hit(K_MEMORY)) begin
                nRoute = RT_MEM; nState = S_ADDR;
              end else if (inByte == CH_QM && hit(K_DEVICE)) begin
                nRoute = RT_DEV; nState = S_QKEY;
              end else if (inByte == CH_SP && hit(K_AUX)) begin
                nRoute = RT_AUX; nState = S_VER;
              end else setErr = 1'b1;
            end else stb.segPush = 1'b1;
          end
          S_ADDR: begin
            if (isDigit)               stb.digitAddr = 1'b1;
            else if (inByte == CH_QM)  nState = S_QKEY;
            else if (inByte == CH_SP)  nState = S_VER;
            else                       setErr = 1'b1;
          end
          S_QKEY: begin
            if (inByte == CH_EQ) begin
              stb.segClr = 1'b1;
              nState     = S_QVAL;
              if (route == RT_MEM && hit(K_SIZE) && !haveSize)        nField = F_SIZE;
              else if (route == RT_DEV && hit(K_IADDR) && !haveAddr)  nField = F_ADDR;
              else if (route == RT_DEV && hit(K_ICOUNT) && !haveSize) nField = F_SIZE;
              else                                                    setErr = 1'b1;
            end else stb.segPush = 1'b1;
          end
          S_QVAL: begin
            if (isDigit) begin
              stb.digitAddr = (fieldSel == F_ADDR);
              stb.digitSize = (fieldSel == F_SIZE);
            end else if ((inByte == CH_AMP || inByte == CH_SP) && !fieldEmpty) begin
              nState = (inByte == CH_AMP) ? S_QKEY : S_VER;
            end else setErr = 1'b1;
          end
          S_VER:   if (inByte == CH_CR) nState = S_LF;
          S_LF: begin
            if (inByte == CH_LF) nState = S_DRAIN;
            else                 setErr = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stb.clrAll) begin
      state    <= S_METH;
      method   <= M_NONE;
      route    <= RT_NONE;
      fieldSel <= F_ADDR;
      parseErr <= 1'b0;
    end else if (accept) begin
      state    <= setErr ? S_DRAIN : nState;
      method   <= nMethod;
      route    <= nRoute;
      fieldSel <= nField;
      parseErr <= parseErr | setErr;
    end
  end
endmodule

// File: rtl/rest_cmd_decoder.sv
`timescale 1ns/1ps
module rest_cmd_decoder
  import rest_cmd_pkg::*;
#(
  parameter int FIELD_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         inData,
  input  logic               inValid,
  input  logic               inLast,
  output logic               inReady,
  output logic               cmdValid,
  input  logic               cmdReady,
  output logic [2:0]         cmdOp,
  output logic [FIELD_W-1:0] cmdAddr,
  output logic [FIELD_W-1:0] cmdSize,
  output logic               cmdErr
);
  dp_strobe_t       stb;
  logic [SEG_W-1:0] segWord;
  logic             segOver, haveAddr, haveSize, ovf, accept;

  assign inReady = !cmdValid || cmdReady;
  assign accept  = inValid && inReady;

  rest_parse_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inByte(inData), .accept(accept), .inLast(inLast),
    .segWord(segWord), .segOver(segOver), .haveAddr(haveAddr),
    .haveSize(haveSize), .ovf(ovf), .stb(stb)
  );

  rest_field_dp #(.FIELD_W(FIELD_W)) u_dp (
    .clk(clk), .rst(rst), .inByte(inData), .stb(stb), .cmdReady(cmdReady),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdSize(cmdSize),
    .cmdErr(cmdErr), .segWord(segWord), .segOver(segOver),
    .haveAddr(haveAddr), .haveSize(haveSize), .ovf(ovf)
  );
endmodule

// File: rtl/rest_cmd_checker.sv
`timescale 1ns/1ps
module rest_cmd_checker #(
  parameter int FIELD_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic               inLast,
  input logic               inReady,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic [2:0]         cmdOp,
  input logic [FIELD_W-1:0] cmdAddr,
  input logic [FIELD_W-1:0] cmdSize,
  input logic               cmdErr
);
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdOp) && $stable(cmdAddr)
                                 && $stable(cmdSize) && $stable(cmdErr)));

  assert_backpressure_R9: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdReady) |-> !inReady);

  assert_emit_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cmdValid) |-> $past(inValid && inReady && inLast));

  assert_aux_no_fields_R4: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 3'd3) |-> (cmdAddr == '0 && cmdSize == '0 && !cmdErr));

  assert_error_record_R5: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdErr) |-> (cmdOp == 3'd7 && cmdAddr == '0 && cmdSize == '0));
endmodule

bind rest_cmd_decoder rest_cmd_checker #(.FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast), .inReady(inReady),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
  .cmdSize(cmdSize), .cmdErr(cmdErr)
);

// File: tb/test_rest_cmd_decoder.sv
`timescale 1ns/1ps
module test_rest_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  inData = 8'd0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic        cmdValid;
  logic        cmdReady = 1'b1;
  logic [2:0]  cmdOp;
  logic [63:0] cmdAddr, cmdSize;
  logic        cmdErr;

  int checks = 0;
  int fails = 0;

  localparam string CRLF = "\015\012";
  localparam string VER  = " HTTP/1.1";
  localparam logic [63:0] MAX64 = 64'hFFFF_FFFF_FFFF_FFFF;

  always #4 clk = ~clk;

  rest_cmd_decoder i_rest_cmd_decoder (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdSize(cmdSize), .cmdErr(cmdErr)
  );

  task automatic check(input bit ok, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", what);
    end
  endtask

  // Starts and ends at a negative edge; returns in the cycle after last is accepted.
  task automatic sendStr(input string s, input bit gaps);
    for (int i = 0; i < s.len(); i++) begin
      if (gaps && $urandom_range(3) == 0) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      inData  = s[i];
      inValid = 1'b1;
      inLast  = (i == s.len() - 1);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic expectCmd(input string tag, input logic [2:0] op,
                           input logic [63:0] a, input logic [63:0] s);
    checks++;
    if (cmdValid !== 1'b1 || cmdOp !== op || cmdAddr !== a || cmdSize !== s
        || cmdErr !== (op == 3'd7)) begin
      fails++;
      $display("FAIL %s: got valid=%0d op=%0d addr=%0d size=%0d err=%0d, expected valid=1 op=%0d addr=%0d size=%0d err=%0d",
               tag, cmdValid, cmdOp, cmdAddr, cmdSize, cmdErr, op, a, s, (op == 3'd7));
    end
  endtask

  task automatic runReq(input string tag, input string req, input bit gaps,
                        input logic [2:0] op, input logic [63:0] a, input logic [63:0] s);
    sendStr(req, gaps);
    expectCmd(tag, op, a, s);
  endtask

  function automatic logic [63:0] rand64();
    logic [63:0] v = {$urandom(), $urandom()};
    return v >> $urandom_range(63, 0);
  endfunction

  function automatic string tail();
    if ($urandom_range(1) == 1) return {CRLF, "Host: x", CRLF, CRLF};
    return CRLF;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(cmdValid === 1'b0, $sformatf("R10 reset cmdValid got %0d expected 0", cmdValid));
    check(inReady === 1'b1, $sformatf("R10 reset inReady got %0d expected 1", inReady));

    // Directed cases
    runReq("R1 read", {"GET /memory/4096?size=256", VER, CRLF}, 0, 3'd0, 64'd4096, 64'd256);
    runReq("R2 write no size", {"PUT /memory/77", VER, CRLF}, 0, 3'd1, 64'd77, 64'd0);
    runReq("R2 write with size", {"PUT /memory/5?size=9", VER, CRLF}, 1, 3'd1, 64'd5, 64'd9);
    runReq("R3 launch order a", {"POST /device?insn_addr=100&insn_count=7", VER, CRLF}, 0, 3'd2, 64'd100, 64'd7);
    runReq("R3 launch swapped", {"POST /device?insn_count=3&insn_addr=42", VER, CRLF}, 0, 3'd2, 64'd42, 64'd3);
    runReq("R4 aux", {"POST /processing_logic", VER, CRLF}, 0, 3'd3, 64'd0, 64'd0);
    runReq("R5 unknown method", {"DELETE /memory/1", VER, CRLF}, 0, 3'd7, 64'd0, 64'd0);
    runReq("R5 unknown path", {"GET /memoryx/1?size=2", VER, CRLF}, 0, 3'd7, 64'd0, 64'd0);
    runReq("R5 missing size", {"GET /memory/12", VER, CRLF}, 0, 3'd7, 64'd0, 64'd0);
    runReq("R5 non-digit", {"GET /memory/12a?size=4", VER, CRLF}, 0, 3'd7, 64'd0, 64'd0);
    runReq("R5 repeated key", {"POST /device?insn_addr=1&insn_addr=2&insn_count=3", VER, CRLF}, 0, 3'd7, 64'd0, 64'd0);
    runReq("R5 empty value", {"POST /device?insn_addr=&insn_count=3", VER, CRLF}, 0, 3'd7, 64'd0, 64'd0);
    runReq("R5 wrong key", {"POST /device?insn_addr=1&insn_cnt=3", VER, CRLF}, 0, 3'd7, 64'd0, 64'd0);
    runReq("R5 wrong method for route", {"GET /processing_logic", VER, CRLF}, 0, 3'd7, 64'd0, 64'd0);
    runReq("R6 max value", {"GET /memory/18446744073709551615?size=1", VER, CRLF}, 0, 3'd0, MAX64, 64'd1);
    runReq("R6 overflow", {"GET /memory/18446744073709551616?size=1", VER, CRLF}, 0, 3'd7, 64'd0, 64'd0);
    runReq("R7 trailing headers", {"PUT /memory/31", VER, CRLF, "Host: GET /memory/9?size=1", CRLF, CRLF}, 1, 3'd1, 64'd31, 64'd0);
    runReq("R7 truncated", "GET /memory/5?size=3", 0, 3'd7, 64'd0, 64'd0);

    // R8: one command per packet, gone the cycle after it is taken
    @(negedge clk);
    check(cmdValid === 1'b0, $sformatf("R8 single command got cmdValid=%0d expected 0", cmdValid));

    // R9: stall at the command port
    cmdReady = 1'b0;
    sendStr({"POST /device?insn_addr=8&insn_count=2", VER, CRLF}, 0);
    for (int k = 0; k < 4; k++) begin
      expectCmd("R9 held during stall", 3'd2, 64'd8, 64'd2);
      check(inReady === 1'b0, $sformatf("R9 inReady during stall got %0d expected 0", inReady));
      @(negedge clk);
    end
    cmdReady = 1'b1;
    expectCmd("R9 released", 3'd2, 64'd8, 64'd2);
    @(negedge clk);
    check(cmdValid === 1'b0, $sformatf("R9 after release got cmdValid=%0d expected 0", cmdValid));

    // R10: reset in the middle of a request
    sendStr("POST /dev", 0);
    inData = 8'h69; inValid = 1'b1; inLast = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmdValid === 1'b0, $sformatf("R10 reset mid-request got cmdValid=%0d expected 0", cmdValid));
    runReq("R10 fresh after reset", {"GET /memory/7?size=8", VER, CRLF}, 0, 3'd0, 64'd7, 64'd8);

    // Random traffic
    for (int it = 0; it < 60; it++) begin
      logic [63:0] a = rand64();
      logic [63:0] s = rand64();
      int kind = $urandom_range(4);
      case (kind)
        0: runReq("R1 random read", {$sformatf("GET /memory/%0d?size=%0d", a, s), VER, tail()}, 1, 3'd0, a, s);
        1: if ($urandom_range(1) == 1)
             runReq("R2 random write", {$sformatf("PUT /memory/%0d?size=%0d", a, s), VER, tail()}, 1, 3'd1, a, s);
           else
             runReq("R2 random write", {$sformatf("PUT /memory/%0d", a), VER, tail()}, 1, 3'd1, a, 64'd0);
        2: if ($urandom_range(1) == 1)
             runReq("R3 random launch", {$sformatf("POST /device?insn_addr=%0d&insn_count=%0d", a, s), VER, tail()}, 1, 3'd2, a, s);
           else
             runReq("R3 random launch", {$sformatf("POST /device?insn_count=%0d&insn_addr=%0d", s, a), VER, tail()}, 1, 3'd2, a, s);
        3: runReq("R4 random aux", {"POST /processing_logic", VER, tail()}, 1, 3'd3, 64'd0, 64'd0);
        default: runReq("R5 random missing size", {$sformatf("GET /memory/%0d", a), VER, tail()}, 1, 3'd7, 64'd0, 64'd0);
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule